// File: doc/BRIEF.md
# Multi-Write-Point Page Allocator

This block decides which physical flash page receives each logical write in an array that keeps several append points open at once. A request carries a logical block address (LBA). The block picks one write point and returns that point's current block and page. It records which write point now holds the address and moves the chosen point to its next page.

Each write point owns one erased block at a time and carries a sequence number. Once an address has been written, its later writes may only go to the same write point or to one with a strictly larger sequence number. This keeps the freshest copy of any address recoverable from ordering alone. Among the allowed points, the one with the smallest sequence number wins. Ties are broken round-robin.

When a write fills the last page of a block, the write point draws a new erased block from a FIFO pool of free blocks. That block is stamped with the highest sequence number issued so far plus one. While a write point is waiting for its new block, the request side is held not-ready. Freed blocks come back into the pool through a release port.

Top module: `wp_page_alloc`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid is 0. Write point w holds block w at page 0 with sequence number 0. The round-robin pointer is 0, and the free pool holds blocks NUM_WP up to NUM_BLK-1 in ascending FIFO order.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. On the next cycle, resp_valid is 1 and resp_wp, resp_blk and resp_page show the chosen write point's block and page as they were before the write. If that page was not the last one in the block, the write point's page then advances by one.
- R3: For an LBA never written since reset, every write point is eligible.
- R4: For an LBA last written through write point p, only p and write points whose sequence number is strictly greater than p's current one are eligible.
- R5: Among the eligible write points, the one with the smallest sequence number is chosen. Ties are settled by scanning from the round-robin pointer upward, with wrap-around. After each accepted write, the pointer moves to one past the chosen write point.
- R6: A write to page PAGES-1 (63 by default) fills the block. On the cycle after that write, req_ready is 0. The write point then takes the oldest block in the free pool, gets a sequence number one greater than the largest issued so far, and restarts at page 0.
- R7: If the free pool is empty when a write point needs a block, req_ready stays 0 until a block arrives on the release port (rel_valid=1, rel_blk = id). That block is pushed into the pool and then given to the waiting write point.
- R8: resp_valid is 1 for exactly one cycle per accepted request and is 0 in every cycle that does not follow an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_lba | input | LBA_W | Logical block address of the write |
| req_ready | output | 1 | Allocator can accept a request |
| rel_valid | input | 1 | Return a block to the free pool |
| rel_blk | input | BLK_W | Id of the returned block |
| resp_valid | output | 1 | Allocation result valid |
| resp_wp | output | WP_W | Chosen write point |
| resp_blk | output | BLK_W | Physical block of the page |
| resp_page | output | PG_W | Page within the block |

## Verification
The first addresses written are all fresh, so every write point is eligible. Because all sequence numbers start equal, this pattern tests only the round-robin tie-break. Rewriting an address before any refill tests the ordering rule: with all numbers still equal, only the previous write point qualifies. A long random mix over a small address range carries write points across block boundaries, so their sequence numbers diverge. This separates minimum-sequence choice, eligibility and FIFO refill order. Running the pool dry tests the not-ready stall and its release by returned blocks.

// File: rtl/wp_page_alloc.sv
module wp_page_alloc #(
  parameter int NUM_WP  = 4,
  parameter int PAGES   = 64,
  parameter int NUM_BLK = 16,
  parameter int LBA_W   = 4,
  parameter int SEQ_W   = 8,
  localparam int WP_W   = $clog2(NUM_WP),
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int PG_W   = $clog2(PAGES),
  localparam int NUM_LBA = 1 << LBA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LBA_W-1:0] req_lba,
  output logic             req_ready,
  input  logic             rel_valid,
  input  logic [BLK_W-1:0] rel_blk,
  output logic             resp_valid,
  output logic [WP_W-1:0]  resp_wp,
  output logic [BLK_W-1:0] resp_blk,
  output logic [PG_W-1:0]  resp_page
);
  localparam logic [PG_W-1:0] LAST_PG = PG_W'(PAGES - 1);

  logic [BLK_W-1:0] wp_blk  [NUM_WP];
  logic [PG_W-1:0]  wp_page [NUM_WP];
  logic [SEQ_W-1:0] wp_seq  [NUM_WP];
  logic [NUM_WP-1:0] need;
  logic [SEQ_W-1:0] gmax;
  logic [WP_W-1:0]  rr;

  logic             tbl_v  [NUM_LBA];
  logic [WP_W-1:0]  tbl_wp [NUM_LBA];

  logic [BLK_W-1:0] pool [NUM_BLK];
  logic [BLK_W-1:0] rd_ptr, wr_ptr;
  logic [BLK_W:0]   cnt;

  logic known;
  logic [WP_W-1:0] prev, pick, ridx;
  logic accept, refill_go, push;

  assign known     = tbl_v[req_lba];
  assign prev      = tbl_wp[req_lba];
  assign req_ready = ~|need;
  assign accept    = req_valid & req_ready;
  assign refill_go = (|need) && (cnt != '0);
  assign push      = rel_valid && (cnt != (BLK_W+1)'(NUM_BLK) || refill_go);

  always_comb begin
    logic found;
    logic [WP_W-1:0] idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_WP; k++) begin
      idx = WP_W'((int'(rr) + k) % NUM_WP);
      if ((!known || idx == prev || wp_seq[idx] > wp_seq[prev]) &&
          (!found || wp_seq[idx] < wp_seq[pick])) begin
        pick  = idx;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    ridx = '0;
    for (int w = NUM_WP - 1; w >= 0; w--)
      if (need[w]) ridx = WP_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WP; w++) begin
        wp_blk[w]  <= BLK_W'(w);
        wp_page[w] <= '0;
        wp_seq[w]  <= '0;
      end
      for (int a = 0; a < NUM_LBA; a++) begin
        tbl_v[a]  <= 1'b0;
        tbl_wp[a] <= '0;
      end
      for (int b = 0; b < NUM_BLK; b++)
        pool[b] <= BLK_W'((b + NUM_WP) % NUM_BLK);
      need       <= '0;
      gmax       <= '0;
      rr         <= '0;
      rd_ptr     <= '0;
      wr_ptr     <= BLK_W'(NUM_BLK - NUM_WP);
      cnt        <= (BLK_W+1)'(NUM_BLK - NUM_WP);
      resp_valid <= 1'b0;
      resp_wp    <= '0;
      resp_blk   <= '0;
      resp_page  <= '0;
    end else begin
      resp_valid <= accept;
      if (accept) begin
        resp_wp         <= pick;
        resp_blk        <= wp_blk[pick];
        resp_page       <= wp_page[pick];
        tbl_v[req_lba]  <= 1'b1;
        tbl_wp[req_lba] <= pick;
        rr              <= (int'(pick) == NUM_WP - 1) ? '0 : pick + 1'b1;
        if (wp_page[pick] == LAST_PG) begin
          wp_page[pick] <= '0;
          need[pick]    <= 1'b1;
        end else begin
          wp_page[pick] <= wp_page[pick] + 1'b1;
        end
      end
      if (refill_go) begin
        wp_blk[ridx] <= pool[rd_ptr];
        wp_seq[ridx] <= gmax + 1'b1;
        gmax         <= gmax + 1'b1;
        need[ridx]   <= 1'b0;
        rd_ptr       <= (int'(rd_ptr) == NUM_BLK - 1) ? '0 : rd_ptr + 1'b1;
      end
      if (push) begin
        pool[wr_ptr] <= rel_blk;
        wr_ptr       <= (int'(wr_ptr) == NUM_BLK - 1) ? '0 : wr_ptr + 1'b1;
      end
      cnt <= cnt + (push ? 1'b1 : 1'b0) - (refill_go ? 1'b1 : 1'b0);
    end
  end

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !resp_valid); // R8
  AST_ORDER_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && known) |-> (pick == prev || wp_seq[pick] > wp_seq[prev])); // R4
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_page != LAST_PG) |-> wp_page[resp_wp] == resp_page + 1'b1); // R2
  AST_FILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_page == LAST_PG) |-> !req_ready); // R6
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    refill_go |=> gmax == $past(gmax) + 1'b1); // R6
endmodule

// File: tb/wp_page_alloc_tb.sv
module wp_page_alloc_tb;
  localparam int NWP = 4, PG = 64, NBLK = 16, LW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rel_valid = 0;
  logic [LW-1:0] req_lba = '0;
  logic [3:0] rel_blk = '0;
  logic req_ready, resp_valid;
  logic [1:0] resp_wp;
  logic [3:0] resp_blk;
  logic [5:0] resp_page;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_blk[NWP], m_page[NWP], m_seq[NWP];
  int m_need = -1;
  int m_rr = 0, m_gmax = 0;
  bit m_v[1 << LW];
  int m_wp[1 << LW];
  int q[$];

  always #10 clk = ~clk;

  wp_page_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lba(req_lba),
    .req_ready(req_ready), .rel_valid(rel_valid), .rel_blk(rel_blk),
    .resp_valid(resp_valid), .resp_wp(resp_wp), .resp_blk(resp_blk),
    .resp_page(resp_page));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mpick(int lba);
    int best = -1;
    for (int k = 0; k < NWP; k++) begin
      int idx = (m_rr + k) % NWP;
      bit el = !m_v[lba] || idx == m_wp[lba] || m_seq[idx] > m_seq[m_wp[lba]];
      if (el && (best < 0 || m_seq[idx] < m_seq[best])) best = idx;
    end
    return best;
  endfunction

  task automatic mrefill();
    if (m_need >= 0 && q.size() > 0) begin
      m_blk[m_need]  = q.pop_front();
      m_gmax++;
      m_seq[m_need]  = m_gmax;
      m_page[m_need] = 0;
      m_need = -1;
    end
  endtask

  task automatic release_blk(int b);
    @(negedge clk);
    rel_valid = 1; rel_blk = 4'(b);
    @(negedge clk);
    rel_valid = 0;
    q.push_back(b);
  endtask

  task automatic do_write(int lba, string tag);
    int p = mpick(lba);
    int eb = m_blk[p], ep = m_page[p];
    @(negedge clk);
    req_valid = 1; req_lba = LW'(lba);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid == 1, {tag, " R2 valid"}, resp_valid, 1);
    chk(resp_wp == p, {tag, " wp"}, resp_wp, p);
    chk(resp_blk == eb, {tag, " R2 blk"}, resp_blk, eb);
    chk(resp_page == ep, {tag, " R2 page"}, resp_page, ep);
    m_v[lba] = 1; m_wp[lba] = p;
    m_rr = (p + 1) % NWP;
    if (ep == PG - 1) begin
      chk(req_ready == 0, "R6 stall after fill", req_ready, 0);
      m_need = p;
    end else m_page[p] = ep + 1;
    @(negedge clk);
    chk(resp_valid == 0, "R8 single pulse", resp_valid, 0);
    if (m_need >= 0 && q.size() == 0) begin
      repeat (4) begin
        @(negedge clk);
        chk(req_ready == 0, "R7 empty pool stall", req_ready, 0);
      end
      release_blk($urandom_range(NBLK - 1));
      release_blk($urandom_range(NBLK - 1));
    end
    mrefill();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < NWP; w++) begin
      m_blk[w] = w; m_page[w] = 0; m_seq[w] = 0;
    end
    for (int b = NWP; b < NBLK; b++) q.push_back(b);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(resp_valid == 0, "R1 no resp", resp_valid, 0);
    for (int a = 0; a < NWP; a++) do_write(a, "R3 fresh lba");
    do_write(0, "R4 rewrite");
    do_write(9, "R3 fresh after wrap");
    for (int i = 0; i < 2000; i++) do_write($urandom_range((1 << LW) - 1), "R5 random");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule